// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Receiver

This block accepts a synchronous serial programming stream, made of a data line and a serial clock, and loads a bank of eight frequency-synthesizer control registers. Both serial lines pass through two-flop synchronizers into the system clock domain. The data line is sampled on each rising edge of the serial clock.

The receiver starts out locked. It needs an unlock run of ones, a start bit and then 24 data bits. Each data bit is sent as a pair of half-bits. A stop symbol then loads the payload into the register chosen by the word's address field. Any protocol error drives an active-low error flag that stays low until the next unlock, and the word is thrown away. After every load or error the receiver locks again.

Top module: `prog_rx`

## Requirements
- R1: After reset err_no is 1, load_o is 0 and every field of regs_o is zero.
- R2: The receiver arms only after at least 5 consecutive sampled 1s followed by a sampled 0. A shorter run of ones does not arm it: a following word causes no load and leaves err_no unchanged.
- R3: The sample after the unlock is the start bit and must be 0. A 1 there sets the error, and nothing is loaded.
- R4: A data half-bit pair with both halves 0 sets the error (encoding error), and nothing is loaded.
- R5: A data bit of 1 is sent as the pair (0,1) and a data bit of 0 as the pair (1,0). The second half is the bit value.
- R6: The first 3 data bits form the address, LSB first. The next 21 bits form the payload, LSB first.
- R7: The stop symbol is the pair (1,1) after exactly 24 data bits. It writes the payload to register field [addr*21 +: 21] of regs_o. In the cycle the new value appears, load_o is 1 for one cycle, with load_addr_o and load_data_o carrying the address and the payload.
- R8: A stop symbol (1,1) before 24 data bits is a word-length error: the error is set and no register changes.
- R9: A valid data pair after 24 data bits (overrun) sets the error, discards the word and changes no register.
- R10: A (0,0) pair in the stop position is a stop-bit error: the error is set and no register changes.
- R11: Once the error is set, err_no stays 0 until the next complete unlock sequence drives it back to 1.
- R12: After a successful load the receiver is locked again. A word sent without a new unlock causes no load and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, sampled on the rising edge of sclk_i |
| err_no | output | 1 | Latched protocol error, active low |
| load_o | output | 1 | One-cycle strobe when a register is written |
| load_addr_o | output | 3 | Address of the register just written |
| load_data_o | output | 21 | Payload just written |
| regs_o | output | 168 | Eight 21-bit destination registers, register k at [k*21 +: 21] |

## Verification
The bench aims at the length boundaries. It sends short words of 0 and 23 bits and an extra data pair after bit 24. A receiver with an off-by-one bit counter would load a truncated word there, or accept the overrun. It also sends 4-one runs that must not arm the receiver, and repeats a word with no new unlock after a load. A receiver that failed to lock again would write a register on the second word. It checks that err_no recovers exactly at the next unlock and not before. It also checks that address and payload land at the right bit positions, so a receiver that packed bits MSB first or mixed up the two halves of a pair would write the wrong register or a reflected value.

// File: rtl/prog_rx_pkg.sv
package prog_rx_pkg;
  typedef enum logic [1:0] {
    ST_LOCK  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/prog_rx_sync.sv
module prog_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdata_i,
  output logic sample_o,
  output logic bit_o
);
  logic [STAGES-1:0] sclk_q, data_q;
  logic              sclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= '0;
      data_q      <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_q      <= {sclk_q[STAGES-2:0], sclk_i};
      data_q      <= {data_q[STAGES-2:0], sdata_i};
      sclk_prev_q <= sclk_q[STAGES-1];
    end
  end

  assign sample_o = sclk_q[STAGES-1] & ~sclk_prev_q;
  assign bit_o    = data_q[STAGES-1];
endmodule

// File: rtl/prog_rx_fsm.sv
module prog_rx_fsm
  import prog_rx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int UNLOCK_ONES = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              load_req_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_o
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int ONES_W = $clog2(UNLOCK_ONES + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ONES_W-1:0] ones_q;
  logic              half_q, first_q, err_q;
  logic [WORD_W-1:0] shreg_q;
  logic              full, pair_end;

  assign full       = (cnt_q == CNT_W'(WORD_W));
  assign pair_end   = sample_i && (state_q == ST_DATA) && half_q;
  assign load_req_o = pair_end && first_q && bit_i && full;
  assign word_o     = shreg_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCK;
      cnt_q   <= '0;
      ones_q  <= '0;
      half_q  <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      shreg_q <= '0;
    end else if (sample_i) begin
      unique case (state_q)
        ST_LOCK: begin
          if (bit_i) begin
            if (ones_q != ONES_W'(UNLOCK_ONES)) ones_q <= ones_q + 1'b1;
          end else begin
            if (ones_q == ONES_W'(UNLOCK_ONES)) begin
              state_q <= ST_START;
              err_q   <= 1'b0;
            end
            ones_q <= '0;
          end
        end
        ST_START: begin
          if (bit_i) begin
            err_q   <= 1'b1;
            state_q <= ST_LOCK;
          end else begin
            state_q <= ST_DATA;
            cnt_q   <= '0;
            half_q  <= 1'b0;
          end
        end
        ST_DATA: begin
          if (!half_q) begin
            first_q <= bit_i;
            half_q  <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (first_q != bit_i) begin
              if (full) begin          // overrun
                err_q   <= 1'b1;
                state_q <= ST_LOCK;
              end else begin
                shreg_q <= {bit_i, shreg_q[WORD_W-1:1]};
                cnt_q   <= cnt_q + 1'b1;
              end
            end else begin
              // (1,1) at full is the load; any other equal pair is an error
              if (!(bit_i && full)) err_q <= 1'b1;
              state_q <= ST_LOCK;
            end
          end
        end
        default: state_q <= ST_LOCK;
      endcase
    end
  end
endmodule

// File: rtl/prog_rx_regs.sv
module prog_rx_regs #(
  parameter int ADDR_W = 3,
  parameter int PAY_W  = 21
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [PAY_W-1:0]                data_i,
  output logic                            load_o,
  output logic [ADDR_W-1:0]               addr_o,
  output logic [PAY_W-1:0]                data_o,
  output logic [(1<<ADDR_W)*PAY_W-1:0]    regs_o
);
  localparam int NREG = 1 << ADDR_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      load_o <= load_i;
      if (load_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_o[g*PAY_W +: PAY_W] <= '0;
      else if (load_i && addr_i == ADDR_W'(g))      regs_o[g*PAY_W +: PAY_W] <= data_i;
    end
  end
endmodule

// File: rtl/prog_rx.sv
module prog_rx #(
  parameter int ADDR_W      = 3,
  parameter int WORD_W      = 24,
  parameter int UNLOCK_ONES = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       sclk_i,
  input  logic                                       sdata_i,
  output logic                                       err_no,
  output logic                                       load_o,
  output logic [ADDR_W-1:0]                          load_addr_o,
  output logic [WORD_W-ADDR_W-1:0]                   load_data_o,
  output logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0]     regs_o
);
  localparam int PAY_W = WORD_W - ADDR_W;

  logic              sample, sbit, load_req, err;
  logic [WORD_W-1:0] word;

  prog_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .sdata_i,
    .sample_o(sample), .bit_o(sbit)
  );

  prog_rx_fsm #(.WORD_W(WORD_W), .UNLOCK_ONES(UNLOCK_ONES)) u_fsm (
    .clk_i, .rst_ni,
    .sample_i(sample), .bit_i(sbit),
    .load_req_o(load_req), .word_o(word), .err_o(err)
  );

  prog_rx_regs #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_regs (
    .clk_i, .rst_ni,
    .load_i(load_req),
    .addr_i(word[ADDR_W-1:0]),
    .data_i(word[WORD_W-1:ADDR_W]),
    .load_o(load_o), .addr_o(load_addr_o), .data_o(load_data_o),
    .regs_o(regs_o)
  );

  assign err_no = ~err;
endmodule

// File: rtl/prog_rx_chk.sv
module prog_rx_chk #(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 24
) (
  input logic                                    clk_i,
  input logic                                    rst_ni,
  input logic                                    err_no,
  input logic                                    load_o,
  input logic [ADDR_W-1:0]                       load_addr_o,
  input logic [WORD_W-ADDR_W-1:0]                load_data_o,
  input logic [(1<<ADDR_W)*(WORD_W-ADDR_W)-1:0]  regs_o
);
  localparam int PAY_W = WORD_W - ADDR_W;

  assert_strobe_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  assert_load_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> regs_o[load_addr_o*PAY_W +: PAY_W] == load_data_o);

  // R8 R9 R10 R12: registers move only with a load
  assert_regs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |-> $stable(regs_o));

  assert_no_load_in_error_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> err_no);

  assert_err_clear_not_on_load_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_no) |-> !load_o);
endmodule

bind prog_rx prog_rx_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_no(err_no), .load_o(load_o),
  .load_addr_o(load_addr_o), .load_data_o(load_data_o), .regs_o(regs_o)
);

// File: tb/prog_rx_test.sv
module prog_rx_test;
  localparam int AW = 3;
  localparam int PW = 21;
  localparam int NR = 8;

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, sdata = 1'b0;
  logic err_no, load_o;
  logic [AW-1:0] load_addr;
  logic [PW-1:0] load_data;
  logic [NR*PW-1:0] regs;

  int checks = 0, errors = 0;
  int loads_seen = 0;
  logic [AW-1:0] cap_addr;
  logic [PW-1:0] cap_data;
  logic [PW-1:0] exp_regs [NR];
  logic exp_err = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prog_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .err_no(err_no), .load_o(load_o), .load_addr_o(load_addr),
    .load_data_o(load_data), .regs_o(regs)
  );

  always @(negedge clk) if (rst_ni && load_o) begin
    loads_seen <= loads_seen + 1;
    cap_addr   <= load_addr;
    cap_data   <= load_data;
  end

  function automatic logic [NR*PW-1:0] pack_exp();
    logic [NR*PW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*PW +: PW] = exp_regs[i];
    return v;
  endfunction

  function automatic logic word_bit(logic [AW-1:0] a, logic [PW-1:0] p, int i);
    return (i < AW) ? a[i] : p[i-AW];
  endfunction

  task automatic check(string req, logic [NR*PW-1:0] act, logic [NR*PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_raw(logic b);
    @(negedge clk) sdata = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (5) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_pair(logic a, logic b);
    send_raw(a);
    send_raw(b);
  endtask

  task automatic send_unlock(int n);
    repeat (n) send_raw(1'b1);
    send_raw(1'b0);
  endtask

  task automatic send_bits(logic [AW-1:0] a, logic [PW-1:0] p, int n);
    for (int i = 0; i < n; i++) begin
      logic b = word_bit(a, p, i);
      send_pair(~b, b); // R5
    end
  endtask

  // mode: 0 valid, 1 short, 2 overrun, 3 bad stop, 4 encoding, 5 bad start,
  //       6 no unlock, 7 too few ones
  task automatic run_word(int mode, logic [AW-1:0] a, logic [PW-1:0] p, int k);
    int l0 = loads_seen;
    int exp_loads = 0;
    string tag;
    if (k < 0) k = int'($urandom % 24);
    case (mode)
      0: begin
        tag = "R7";
        send_unlock(5 + int'($urandom % 3));
        repeat (3) @(negedge clk);
        check("R11 err cleared by unlock", {{(NR*PW-1){1'b0}}, err_no}, 1);
        exp_err = 1'b0;
        send_raw(1'b0);
        send_bits(a, p, 24);
        send_pair(1'b1, 1'b1);
        exp_regs[a] = p;
        exp_loads = 1;
      end
      1: begin tag = "R8";  send_unlock(5); send_raw(1'b0); send_bits(a, p, k);  send_pair(1'b1, 1'b1); exp_err = 1'b1; end
      2: begin tag = "R9";  send_unlock(5); send_raw(1'b0); send_bits(a, p, 24); send_pair(1'b0, 1'b1); exp_err = 1'b1; end
      3: begin tag = "R10"; send_unlock(5); send_raw(1'b0); send_bits(a, p, 24); send_pair(1'b0, 1'b0); exp_err = 1'b1; end
      4: begin tag = "R4";  send_unlock(5); send_raw(1'b0); send_bits(a, p, k);  send_pair(1'b0, 1'b0); exp_err = 1'b1; end
      5: begin tag = "R3";  send_unlock(5); send_raw(1'b1); exp_err = 1'b1; end
      6: begin tag = "R12"; send_raw(1'b0); send_bits(a, p, 24); send_pair(1'b1, 1'b1); end
      default: begin
        tag = "R2";
        send_raw(1'b0); send_unlock(4); send_raw(1'b0);
        send_bits(a, p, 24); send_pair(1'b1, 1'b1);
      end
    endcase
    repeat (4) @(negedge clk);
    check({tag, " err_no (R11)"}, {{(NR*PW-1){1'b0}}, err_no}, {{(NR*PW-1){1'b0}}, ~exp_err});
    check({tag, " load count"}, (NR*PW)'(loads_seen - l0), (NR*PW)'(exp_loads));
    if (exp_loads == 1) begin
      check("R7 R6 strobe addr", (NR*PW)'(cap_addr), (NR*PW)'(a));
      check("R7 R6 strobe data", (NR*PW)'(cap_data), (NR*PW)'(p));
    end
    check({tag, " regs"}, regs, pack_exp());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) exp_regs[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 err_no", {{(NR*PW-1){1'b0}}, err_no}, 1);
    check("R1 load_o", {{(NR*PW-1){1'b0}}, load_o}, 0);
    check("R1 regs", regs, '0);

    run_word(0, 3'd0, 21'h000001, 0);
    run_word(0, 3'd7, 21'h1FFFFF, 0);
    run_word(6, 3'd1, 21'h0ABCDE, 0);   // R12 no re-unlock
    run_word(0, 3'd5, 21'h000000, 0);
    run_word(0, 3'd2, 21'h100000, 0);   // R6 payload MSB
    run_word(1, 3'd3, 21'h12345, 23);   // R8 one bit short
    run_word(0, 3'd3, 21'h054321, 0);   // R11 recovery
    run_word(1, 3'd4, 21'h0, 0);        // R8 empty word
    run_word(2, 3'd4, 21'h1A2B3C, 0);   // R9
    run_word(3, 3'd6, 21'h0F0F0F, 0);   // R10
    run_word(4, 3'd6, 21'h111111, 0);   // R4 at first bit
    run_word(5, 3'd1, 21'h0, 0);        // R3
    run_word(7, 3'd1, 21'h155555, 0);   // R2 four ones
    run_word(0, 3'd1, 21'h155555, 0);

    for (int it = 0; it < 40; it++) begin
      int r = int'($urandom % 10);
      int mode = (r < 4) ? 0 : r - 3;
      run_word(mode, AW'($urandom), PW'($urandom), -1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule